// File: doc/BRIEF.md
# Bridge Parity Error Forwarding Unit

This block handles one direction of a two-port bridge. It carries a data parity error that the target reports while the bridge writes data into it back to the initiator on the other bus. On each target-side data phase the block samples the target's active-low parity-error line. It sets a sticky status bit when the target-side response enable allows it. It also stores the error as a flag in transaction order.

When the matching data phase later completes on the initiator bus, the block takes that flag out of its store. If the flag is set and both the primary and the secondary response enables are on, it drives the initiator-side parity-error line low for one clock, two clocks after that data phase. The transaction itself completes normally, so the block has no retry or abort path. A second sticky bit records that an error was forwarded. Both status bits clear only when software writes a 1 to their positions.

The parameter `TGT_IS_SEC` picks the direction. With 1 (downstream), the target side is the secondary bus and the secondary enable gates the first status bit. With 0 (upstream), the primary enable gates it.

Top module: `bridge_perr_fwd`

## Requirements
- R1: While reset is held and right after it, `ini_perr_n` is 1 and `sts` is 2'b00.
- R2: A target-side data phase with `tgt_perr_n` low sets `sts[0]` (target data parity detected) when the target-side enable is 1. With that enable at 0 the bit does not change.
- R3: With `TGT_IS_SEC`=1 (the default), the target-side enable is `sec_per_en`. `pri_per_en` alone does not let `sts[0]` be set. With `TGT_IS_SEC`=0 the target-side enable is `pri_per_en`.
- R4: When the initiator-side data phase of a transaction with a saved error is sampled at clock edge k, and `pri_per_en` and `sec_per_en` are both 1 at that edge, `ini_perr_n` is 0 for exactly the clock period that follows edge k+1.
- R5: If either enable is 0 at the initiator-side data phase, no pulse is driven for that transaction and its saved flag is discarded.
- R6: Saved flags are consumed in transaction order. The n-th initiator-side data phase reports the error of the n-th target-side data phase. Up to `DEPTH` transactions may be outstanding.
- R7: A saved flag is cleared when it is consumed. A later clean transaction in the same slot gives no pulse.
- R8: `sts[1]` (error forwarded) becomes 1 in the same cycle that `ini_perr_n` goes low.
- R9: When `sts_wr` is 1, each bit of `sts` whose `sts_wdata` bit is 1 clears. Bits written with 0 keep their value. A set condition in the same cycle wins over the clear.
- R10: Initiator-side data phases on consecutive cycles, each with a saved error, give a pulse on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tgt_perr_n | input | 1 | Target's parity-error line, active low, valid when `tgt_data_phase` is 1 |
| tgt_data_phase | input | 1 | One write data phase delivered on the target bus |
| ini_data_phase | input | 1 | The matching data phase completes on the initiator bus |
| pri_per_en | input | 1 | Primary parity-error response enable |
| sec_per_en | input | 1 | Secondary parity-error response enable |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 2 | Write-1-to-clear mask for `sts` |
| ini_perr_n | output | 1 | Forwarded parity-error line on the initiator bus, active low |
| sts | output | 2 | Sticky status: bit 0 target data parity detected, bit 1 error forwarded |

## Verification
The assertions assume that an initiator-side data phase occurs only while at least one transaction is outstanding. They also assume that no target-side data phase arrives while `DEPTH` transactions are already outstanding, unless one is consumed in the same cycle. In addition, they take the enables to be meaningful only at the clock edges where a data phase is sampled. The random stimulus keeps its own count of outstanding transactions. It raises the initiator strobe only when that count is above zero and the target strobe only when the count is below `DEPTH`. The directed cases follow the same rule.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  localparam int STS_W       = 2;
  localparam int STS_TGT_DPD = 0;  // target data parity detected
  localparam int STS_FWD     = 1;  // error forwarded to initiator
endpackage

// File: rtl/bpf_flag_fifo.sv
// Per-transaction error flags kept in order (R6, R7).
module bpf_flag_fifo #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_flag,
  input  logic pop,
  output logic head_flag
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DEPTH-1:0] mem_q, mem_d;
  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d;

  always_comb begin
    mem_d = mem_q;
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (pop) begin
      mem_d[rp_q] = 1'b0;  // consumed flag is cleared (R7)
      rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    end
    if (push) begin
      mem_d[wp_q] = push_flag;
      wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else begin
      mem_q <= mem_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
    end
  end

  assign head_flag = mem_q[rp_q];
endmodule

// File: rtl/bpf_fwd_pipe.sv
// Two-stage delay from initiator data phase to PERR# pulse (R4, R10).
module bpf_fwd_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic fire,
  output logic perr_n
);
  logic fire_q, fire_d;
  logic perr_n_q, perr_n_d;

  always_comb begin
    fire_d   = launch;
    perr_n_d = ~fire_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q   <= 1'b0;
      perr_n_q <= 1'b1;
    end else begin
      fire_q   <= fire_d;
      perr_n_q <= perr_n_d;
    end
  end

  assign fire   = fire_q;
  assign perr_n = perr_n_q;
endmodule

// File: rtl/bpf_status.sv
// Sticky write-1-to-clear status bits, set has priority (R9).
module bpf_status #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sts
);
  logic [W-1:0] sts_q, sts_d;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      if (set[b])                sts_d[b] = 1'b1;
      else if (wr && wdata[b])   sts_d[b] = 1'b0;
      else                       sts_d[b] = sts_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts = sts_q;
endmodule

// File: rtl/bridge_perr_fwd.sv
module bridge_perr_fwd
  import bpf_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter bit TGT_IS_SEC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_perr_n,
  input  logic             tgt_data_phase,
  input  logic             ini_data_phase,
  input  logic             pri_per_en,
  input  logic             sec_per_en,
  input  logic             sts_wr,
  input  logic [STS_W-1:0] sts_wdata,
  output logic             ini_perr_n,
  output logic [STS_W-1:0] sts
);
  logic rst_meta_q, rst_sync_n;
  logic tgt_en, tgt_err, head_flag, launch, fire;
  logic [STS_W-1:0] sts_set;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // target-side enable depends on direction (R3)
  if (TGT_IS_SEC) begin : g_down
    assign tgt_en = sec_per_en;
  end else begin : g_up
    assign tgt_en = pri_per_en;
  end

  assign tgt_err = tgt_data_phase & ~tgt_perr_n;
  assign launch  = ini_data_phase & head_flag & pri_per_en & sec_per_en;

  always_comb begin
    sts_set              = '0;
    sts_set[STS_TGT_DPD] = tgt_err & tgt_en;
    sts_set[STS_FWD]     = fire;
  end

  bpf_flag_fifo #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (tgt_data_phase),
    .push_flag (tgt_err),
    .pop       (ini_data_phase),
    .head_flag (head_flag)
  );

  bpf_fwd_pipe u_pipe (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .launch (launch),
    .fire   (fire),
    .perr_n (ini_perr_n)
  );

  bpf_status #(.W(STS_W)) u_sts (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (sts_set),
    .wr    (sts_wr),
    .wdata (sts_wdata),
    .sts   (sts)
  );
endmodule

// File: rtl/bridge_perr_fwd_chk.sv
module bridge_perr_fwd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_perr_n,
  input logic       tgt_data_phase,
  input logic       ini_data_phase,
  input logic       pri_per_en,
  input logic       sec_per_en,
  input logic       sts_wr,
  input logic [1:0] sts_wdata,
  input logic       ini_perr_n,
  input logic [1:0] sts
);
  assert_perr_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ini_perr_n |-> $past(ini_data_phase, 2));

  assert_perr_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ini_perr_n |-> ($past(pri_per_en, 2) && $past(sec_per_en, 2)));

  assert_sts_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> $past(tgt_data_phase && !tgt_perr_n));

  assert_fwd_sts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> !ini_perr_n);

  assert_sticky0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts[0]) |-> $past(sts_wr && sts_wdata[0]));

  assert_sticky1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts[1]) |-> $past(sts_wr && sts_wdata[1]));
endmodule

bind bridge_perr_fwd bridge_perr_fwd_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .tgt_perr_n     (tgt_perr_n),
  .tgt_data_phase (tgt_data_phase),
  .ini_data_phase (ini_data_phase),
  .pri_per_en     (pri_per_en),
  .sec_per_en     (sec_per_en),
  .sts_wr         (sts_wr),
  .sts_wdata      (sts_wdata),
  .ini_perr_n     (ini_perr_n),
  .sts            (sts)
);

// File: tb/tb_bridge_perr_fwd.sv
module tb_bridge_perr_fwd;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic tgt_perr_n, tgt_data_phase, ini_data_phase;
  logic pri_per_en, sec_per_en, sts_wr;
  logic [1:0] sts_wdata;
  logic ini_perr_n;
  logic [1:0] sts;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model state
  bit   q[$];
  bit   m_fire = 1'b0;
  bit   m_perr_n = 1'b1;
  bit [1:0] m_sts = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_perr_fwd #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .tgt_perr_n(tgt_perr_n),
    .tgt_data_phase(tgt_data_phase), .ini_data_phase(ini_data_phase),
    .pri_per_en(pri_per_en), .sec_per_en(sec_per_en),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .ini_perr_n(ini_perr_n), .sts(sts)
  );

  function automatic bit next_sts_bit(bit cur, bit set, bit clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic check(string tag);
    n_checks += 2;
    if (ini_perr_n !== m_perr_n) begin
      n_fail++;
      $display("FAIL %s ini_perr_n actual=%b expected=%b @%0t", tag, ini_perr_n, m_perr_n, $time);
    end
    if (sts !== m_sts) begin
      n_fail++;
      $display("FAIL %s sts actual=%b expected=%b @%0t", tag, sts, m_sts, $time);
    end
  endtask

  // called at a negedge: drive, advance model one edge, compare at next negedge
  task automatic step(string tag, bit t, bit pe_n, bit i, bit p, bit s, bit w, bit [1:0] wd);
    bit head;
    tgt_data_phase = t; tgt_perr_n = pe_n; ini_data_phase = i;
    pri_per_en = p; sec_per_en = s; sts_wr = w; sts_wdata = wd;
    head = (i && q.size() > 0) ? q[0] : 1'b0;
    m_sts[1] = next_sts_bit(m_sts[1], m_fire, w && wd[1]);
    m_sts[0] = next_sts_bit(m_sts[0], t && !pe_n && s, w && wd[0]);
    m_perr_n = !m_fire;
    m_fire   = i && head && p && s;
    if (i && q.size() > 0) void'(q.pop_front());
    if (t) q.push_back(!pe_n);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(string tag, int n, bit p, bit s);
    for (int k = 0; k < n; k++) step(tag, 0, 1, 0, p, s, 0, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    tgt_perr_n = 1'b1; tgt_data_phase = 1'b0; ini_data_phase = 1'b0;
    pri_per_en = 1'b0; sec_per_en = 1'b0; sts_wr = 1'b0; sts_wdata = 2'b00;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    idle("R1", 4, 0, 0);

    // R2: target error with target-side (secondary) enable sets sts[0]
    step("R2", 1, 0, 0, 0, 1, 0, 2'b00);
    idle("R2", 1, 0, 1);
    step("R9", 0, 1, 1, 0, 1, 1, 2'b01);   // clear bit0, drain entry
    idle("R9", 3, 0, 1);
    // R2: enable off -> no status
    step("R2", 1, 0, 0, 0, 0, 0, 2'b00);
    step("R2", 0, 1, 1, 0, 0, 0, 2'b00);
    idle("R2", 3, 0, 0);
    // R3: primary enable alone does not gate sts[0] downstream
    step("R3", 1, 0, 0, 1, 0, 0, 2'b00);
    step("R3", 0, 1, 1, 1, 0, 0, 2'b00);
    idle("R3", 3, 1, 0);

    // R4/R8: forwarded pulse two clocks after initiator data phase
    step("R4", 1, 0, 0, 1, 1, 0, 2'b00);
    idle("R4", 2, 1, 1);
    step("R4", 0, 1, 1, 1, 1, 0, 2'b00);
    idle("R4", 1, 1, 1);
    idle("R8", 3, 1, 1);
    // R9: writing 0 keeps bits, writing 1 to bit1 clears it
    step("R9", 0, 1, 0, 1, 1, 1, 2'b00);
    step("R9", 0, 1, 0, 1, 1, 1, 2'b10);
    step("R9", 0, 1, 0, 1, 1, 1, 2'b01);
    // R9: set wins over clear in the same cycle
    step("R9", 1, 0, 0, 1, 1, 1, 2'b01);
    // R5: primary enable off at the initiator phase
    step("R5", 0, 1, 1, 0, 1, 0, 2'b00);
    idle("R5", 3, 1, 1);
    // R7: clean transaction after a consumed error gives no pulse
    step("R7", 1, 1, 0, 1, 1, 0, 2'b00);
    step("R7", 0, 1, 1, 1, 1, 0, 2'b00);
    idle("R7", 3, 1, 1);
    // R10: back-to-back initiator phases with errors
    step("R10", 1, 0, 0, 1, 1, 0, 2'b00);
    step("R10", 1, 0, 0, 1, 1, 0, 2'b00);
    step("R10", 0, 1, 1, 1, 1, 0, 2'b00);
    step("R10", 0, 1, 1, 1, 1, 0, 2'b00);
    idle("R10", 4, 1, 1);

    // R6: random ordering of pushes and pops
    begin
      bit p = 1'b1, s = 1'b1;
      for (int n = 0; n < 2000; n++) begin
        bit t, i, pe_n, w;
        bit [1:0] wd;
        t    = (q.size() < DEPTH) ? 1'($urandom % 2) : 1'b0;
        i    = (q.size() > 0)     ? 1'($urandom % 2) : 1'b0;
        pe_n = ($urandom % 3) != 0;
        if ($urandom % 10 == 0) p = ~p;
        if ($urandom % 10 == 0) s = ~s;
        w    = ($urandom % 6) == 0;
        wd   = 2'($urandom);
        step("R6", t, pe_n, i, p, s, w, wd);
      end
    end
    idle("R6", 3, 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule